// File: doc/BRIEF.md
# Sized Base Address Window with Hit Decode

This block is one address window of a bus target. Configuration software sees a 32-bit base register in which only the address bits above the window size can be written. All other bits are tied low, and bit 0 carries a fixed space-type indicator. To learn the window size, software writes all ones and reads the register back. The two's complement of that readback is the size. For the default 2 MB window the readback is 0xFFE00000, so the size is 0x00200000. Software then writes a base that is aligned to that size.

The size comes from a 24-bit mask parameter that covers address bits 31:8. Examples are 0xFFE000 for 2 MB and 0xFFF000 for 1 MB. A control register holds an image enable and a translation enable. A translation base register holds a local base, and only its masked bits are stored. On the bus side, every valid address is compared with the stored base under the mask. A hit is registered one cycle later. In the same cycle the block gives a local address. That address is either the incoming address unchanged or, with translation on, the address moved onto the translation base.

Top module: `barWindow`

## Requirements
- R1: After reset, the base register reads back only the type bit (0x00000000 for a memory window), the control register reads 0, the translation base reads 0, and no hit is produced.
- R2: Writing 0xFFFFFFFF to the base register (select 0) reads back {MASK, 8'h00} with the type bit in bit 0. For the default mask this is 0xFFE00000, and the two's complement of the readback is the window size, 0x00200000.
- R3: Base register bits 7:1 always read as zero, and bit 0 always reads as the TYPE_BIT parameter, whatever data is written.
- R4: Byte enable bit k of a configuration write updates only data byte k. Byte 0 never changes stored base or translation bits. Within an enabled byte, bits outside the mask stay zero.
- R5: No register changes when cfgWrite is low. A write to select 3 changes nothing, and select 3 reads as zero.
- R6: Control register (select 1) bit 0 is the image enable and bit 1 is the translation enable. Both are written through byte enable 0. busHit rises one cycle after an address is presented only when busValid was high and the image enable was set.
- R7: A hit needs (busAddr[31:8] & MASK) == (base[31:8] & MASK). Address bits outside the mask have no effect on the hit.
- R8: localAddr is registered one cycle after busAddr. With translation off it equals busAddr. With translation on it equals (translation base under the mask) OR (busAddr outside the mask), and bits 7:0 are passed through.
- R9: The translation base register (select 2) stores only masked bits 31:8. Writing all ones to it reads back {MASK, 8'h00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 base, 1 control, 2 translation base, 3 reserved |
| cfgByteEn | input | 4 | Per-byte write enables |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Combinational readback of the selected register |
| busValid | input | 1 | Bus address qualifier |
| busAddr | input | 32 | Bus address to decode |
| busHit | output | 1 | Registered window hit |
| localAddr | output | 32 | Registered local (possibly translated) address |

## Verification
A configuration write takes effect at the clock edge where it is sampled, and readback is combinational. The bench therefore drives a write on a falling edge and releases it on the next falling edge. It then reads the register a moment after changing cfgSel, with no clock edge in between. Hit and local address are due exactly one rising edge after the address is driven. Each decode probe drives the address on a falling edge and samples busHit and localAddr on the next falling edge. The address sweeps flip every single bit around an aligned base, so each bit's effect on the hit and on translation lands in its own cycle.

// File: rtl/barPkg.sv
package barPkg;
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_CTL   = 2'd1;
  localparam logic [1:0] SEL_TRANS = 2'd2;

  // Write strobes from control to datapath; index 0 is data byte 1.
  typedef struct packed {
    logic [2:0] baseByteWe;
    logic       ctlWe;
    logic [2:0] transByteWe;
  } cfgStrobes_t;
endpackage

// File: rtl/barCtrl.sv
module barCtrl
  import barPkg::*;
(
  input  logic        cfgWrite,
  input  logic [1:0]  cfgSel,
  input  logic [3:0]  cfgByteEn,
  output cfgStrobes_t strb
);
  always_comb begin
    strb = '0;
    if (cfgWrite) begin
      unique case (cfgSel)
        SEL_BASE:  strb.baseByteWe  = cfgByteEn[3:1];
        SEL_CTL:   strb.ctlWe       = cfgByteEn[0];
        SEL_TRANS: strb.transByteWe = cfgByteEn[3:1];
        default:   strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/barDatapath.sv
module barDatapath
  import barPkg::*;
#(
  parameter logic [23:0] MASK     = 24'hFFE000,
  parameter logic        TYPE_BIT = 1'b0
)(
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobes_t strb,
  input  logic [1:0]  cfgSel,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic        busValid,
  input  logic [31:0] busAddr,
  output logic        busHit,
  output logic [31:0] localAddr
);
  localparam int HI_BYTES = 3;

  logic [23:0] baseHi;
  logic [23:0] transHi;
  logic        imgEn;
  logic        transEn;
  logic        unusedLowData;

  assign unusedLowData = ^cfgWdata[7:2];

  // Per-byte storage of the masked high address bits.
  for (genvar gb = 0; gb < HI_BYTES; gb++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseHi[gb*8 +: 8]  <= '0;
        transHi[gb*8 +: 8] <= '0;
      end else begin
        if (strb.baseByteWe[gb])
          baseHi[gb*8 +: 8] <= cfgWdata[(gb+1)*8 +: 8] & MASK[gb*8 +: 8];
        if (strb.transByteWe[gb])
          transHi[gb*8 +: 8] <= cfgWdata[(gb+1)*8 +: 8] & MASK[gb*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imgEn   <= 1'b0;
      transEn <= 1'b0;
    end else if (strb.ctlWe) begin
      imgEn   <= cfgWdata[0];
      transEn <= cfgWdata[1];
    end
  end

  always_comb begin
    unique case (cfgSel)
      SEL_BASE:  cfgRdata = {baseHi, 7'b0, TYPE_BIT};
      SEL_CTL:   cfgRdata = {30'b0, transEn, imgEn};
      SEL_TRANS: cfgRdata = {transHi, 8'b0};
      default:   cfgRdata = '0;
    endcase
  end

  logic        matchNow;
  logic [23:0] mappedHi;
  assign matchNow = (((busAddr[31:8] ^ baseHi) & MASK) == 24'b0);
  assign mappedHi = transEn ? (transHi | (busAddr[31:8] & ~MASK)) : busAddr[31:8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busHit    <= 1'b0;
      localAddr <= '0;
    end else begin
      busHit    <= busValid & imgEn & matchNow;
      localAddr <= {mappedHi, busAddr[7:0]};
    end
  end

  // R2 / R4: bits outside the mask never hold a one.
  p_base_in_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((baseHi & ~MASK) == 24'b0) && ((transHi & ~MASK) == 24'b0));

  // R5: the base holds when no base byte was written.
  p_base_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.baseByteWe == 3'b0) |=> $stable(baseHi));

  // R6: a hit needs a valid address and an enabled image in the prior cycle.
  p_hit_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busHit) |-> $past(busValid) && $past(imgEn));

  // R8: without translation the address passes through one cycle later.
  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(transEn)) |-> (localAddr == $past(busAddr)));

  // R8: the offset below bit 8 is never remapped.
  p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (localAddr[7:0] == $past(busAddr[7:0])));
endmodule

// File: rtl/barWindow.sv
module barWindow
  import barPkg::*;
#(
  parameter logic [23:0] MASK     = 24'hFFE000,
  parameter logic        TYPE_BIT = 1'b0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrite,
  input  logic [1:0]  cfgSel,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic        busValid,
  input  logic [31:0] busAddr,
  output logic        busHit,
  output logic [31:0] localAddr
);
  cfgStrobes_t strb;

  barCtrl u_ctrl (
    .cfgWrite (cfgWrite),
    .cfgSel   (cfgSel),
    .cfgByteEn(cfgByteEn),
    .strb     (strb)
  );

  barDatapath #(.MASK(MASK), .TYPE_BIT(TYPE_BIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .busValid (busValid),
    .busAddr  (busAddr),
    .busHit   (busHit),
    .localAddr(localAddr)
  );
endmodule

// File: tb/barWindow_test.sv
`timescale 1ns/1ps
module barWindow_test;
  localparam logic [23:0] MASK = 24'hFFE000;
  localparam logic [31:0] MASK_FULL = {MASK, 8'h00};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busHit;
  logic [31:0] localAddr;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  barWindow #(.MASK(MASK), .TYPE_BIT(1'b0)) uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .busValid(busValid), .busAddr(busAddr), .busHit(busHit), .localAddr(localAddr)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSel = sel; cfgByteEn = be; cfgWdata = data;
    @(negedge clk);
    cfgWrite = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic cfgRdCheck(input string req, input logic [1:0] sel, input logic [31:0] exp);
    cfgSel = sel;
    #1;
    check(req, cfgRdata, exp);
  endtask

  task automatic probe(input logic valid, input logic [31:0] addr, input logic expHit,
                       input logic [31:0] expLocal, input string reqHit);
    @(negedge clk);
    busValid = valid; busAddr = addr;
    @(negedge clk);
    check(reqHit, {31'b0, busHit}, {31'b0, expHit});
    check("R8 localAddr", localAddr, expLocal);
    busValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    logic [31:0] tbase;
    logic [31:0] rd;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfgRdCheck("R1 base", 2'd0, 32'h0);
    cfgRdCheck("R1 control", 2'd1, 32'h0);
    cfgRdCheck("R1 trans", 2'd2, 32'h0);
    probe(1'b1, 32'h0000_0000, 1'b0, 32'h0000_0000, "R1 no hit");

    // R2 sizing and R3 fixed low bits
    cfgWr(2'd0, 4'hF, 32'hFFFF_FFFF);
    cfgSel = 2'd0; #1; rd = cfgRdata;
    check("R2 readback", rd, 32'hFFE0_0000);
    check("R2 size", (~rd) + 32'd1, 32'h0020_0000);
    check("R3 low byte", {24'b0, rd[7:0]}, 32'h0);

    // R4 byte enable sweep
    for (int be = 0; be < 16; be++) begin
      cfgWr(2'd0, 4'hF, 32'h0);
      cfgWr(2'd0, be[3:0], 32'hFFFF_FFFF);
      exp = '0;
      for (int b = 1; b < 4; b++) if (be[b]) exp |= (32'hFF << (8*b));
      exp &= MASK_FULL;
      cfgRdCheck("R4 byte enable", 2'd0, exp);
    end

    // R5 ignored writes
    base = 32'h4000_0000;
    cfgWr(2'd0, 4'hF, base);
    cfgWr(2'd3, 4'hF, 32'hFFFF_FFFF);
    cfgRdCheck("R5 sel3 reads zero", 2'd3, 32'h0);
    cfgRdCheck("R5 base after sel3", 2'd0, base);
    @(negedge clk);
    cfgSel = 2'd0; cfgByteEn = 4'hF; cfgWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfgByteEn = 4'h0;
    cfgRdCheck("R5 no strobe", 2'd0, base);
    cfgRdCheck("R3 low bits after data", 2'd0, base);

    // R9 translation base
    cfgWr(2'd2, 4'hF, 32'hFFFF_FFFF);
    cfgRdCheck("R9 trans ones", 2'd2, MASK_FULL);
    cfgWr(2'd2, 4'hF, 32'h1234_5678);
    tbase = 32'h1234_5678 & MASK_FULL;
    cfgRdCheck("R9 trans value", 2'd2, tbase);

    // R6 disabled image: no hit
    probe(1'b1, base | 32'h0001_2345, 1'b0, base | 32'h0001_2345, "R6 disabled");

    cfgWr(2'd1, 4'h1, 32'h0000_0001);
    cfgRdCheck("R6 control", 2'd1, 32'h1);
    probe(1'b0, base | 32'h0001_2345, 1'b0, base | 32'h0001_2345, "R6 invalid");

    // R7 single-bit sweep, translation off
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a;
      a = (base | 32'h0001_2345) ^ (32'h1 << i);
      probe(1'b1, a, (((a ^ base) & MASK_FULL) == 32'h0), a, "R7 decode");
    end

    // R8 translation on
    cfgWr(2'd1, 4'h1, 32'h0000_0003);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a;
      a = (base | 32'h0001_2345) ^ (32'h1 << i);
      probe(1'b1, a, (((a ^ base) & MASK_FULL) == 32'h0),
            tbase | (a & ~MASK_FULL), "R8 translate");
    end

    // R6 disable again, translation still on
    cfgWr(2'd1, 4'h1, 32'h0000_0002);
    probe(1'b1, base, 1'b0, tbase, "R6 re-disabled");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule